// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block adds two 64-bit operands as vectors of independent integer lanes. The lane size is byte, 16-bit word or 32-bit doubleword. Each lane's sum is handled in one of three ways: it wraps modulo the lane width, it clamps to the signed range of the lane, or it clamps to the unsigned range of the lane.

The lane size and the overflow handling both come from an 8-bit operation select. This select is the second opcode byte of the packed-add family. Any select value that is not listed below returns a zero result and raises an illegal-operation flag.

The adder is pipelined in two stages. A result leaves two clocks after its operands arrive, and a new operation can be issued on every clock. An issuing unit drives operands together with `inValid`, and the write-back side picks up `result` whenever `outValid` is high.

Top module: `simd_sat_adder`

## Requirements
- R1: Select 0xFC adds eight independent 8-bit lanes and keeps each sum modulo 256.
- R2: Select 0xFE adds two independent 32-bit lanes and keeps each sum modulo 2^32.
- R3: Select 0xEC adds eight signed 8-bit lanes. A sum above +127 gives 0x7F, and a sum below -128 gives 0x80.
- R4: Select 0xED adds four signed 16-bit lanes. A sum above +32767 gives 0x7FFF, and a sum below -32768 gives 0x8000.
- R5: Select 0xDC adds eight unsigned 8-bit lanes. A sum above 255 gives 0xFF.
- R6: `outValid` rises exactly two rising clock edges after the edge that samples `inValid` high, and at no other time.
- R7: In every mode, no carry crosses from one lane into the next lane. Byte lane k occupies bits 8k+7..8k, word lane k occupies bits 16k+15..16k, and dword lane k occupies bits 32k+31..32k.
- R8: Any select value other than 0xFC, 0xFE, 0xEC, 0xED or 0xDC gives a result of zero with `illegalOp` high, in the same cycle as `outValid`. `illegalOp` is never high while `outValid` is low.
- R9: Operations issued on consecutive clocks produce results on consecutive clocks, in issue order.
- R10: While `rstN` is low, `outValid` and `illegalOp` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and select are valid this cycle |
| opSel | input | 8 | Operation select (second opcode byte) |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| outValid | output | 1 | Result is valid this cycle |
| result | output | 64 | Packed sum |
| illegalOp | output | 1 | The select of this result was not recognised |

## Verification
The bench builds the block with its default width of 64 bits. At that width every mode is present: eight byte lanes, four word lanes and two doubleword lanes.

Each mode therefore gets a vector that straddles both its positive and its negative clamp points. Carries also arrive at every byte, word and doubleword boundary. The vector table is streamed back to back, so the throughput check and the ordering check fall out of the same run as the arithmetic checks.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  typedef enum logic [1:0] {LANE_BYTE = 2'd0, LANE_WORD = 2'd1, LANE_DWORD = 2'd2} laneWidth_e;
  typedef enum logic [1:0] {SAT_WRAP = 2'd0, SAT_SIGNED = 2'd1, SAT_UNSIGNED = 2'd2} satMode_e;

  typedef struct packed {
    logic       vld;
    logic       illegal;
    laneWidth_e width;
    satMode_e   sat;
  } addCtrl_t;

  localparam logic [7:0] OP_ADD_B_WRAP  = 8'hFC;
  localparam logic [7:0] OP_ADD_D_WRAP  = 8'hFE;
  localparam logic [7:0] OP_ADD_B_SSAT  = 8'hEC;
  localparam logic [7:0] OP_ADD_W_SSAT  = 8'hED;
  localparam logic [7:0] OP_ADD_B_USAT  = 8'hDC;
endpackage

// File: rtl/simd_add_ctrl.sv
module simd_add_ctrl
  import simd_add_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] opSel,
  output addCtrl_t   stage1Ctrl,
  output logic       outValid,
  output logic       illegalOp
);
  addCtrl_t decoded;

  always_comb begin
    decoded         = '0;
    decoded.vld     = inValid;
    decoded.width   = LANE_BYTE;
    decoded.sat     = SAT_WRAP;
    decoded.illegal = 1'b0;
    case (opSel)
      OP_ADD_B_WRAP: begin decoded.width = LANE_BYTE;  decoded.sat = SAT_WRAP;     end
      OP_ADD_D_WRAP: begin decoded.width = LANE_DWORD; decoded.sat = SAT_WRAP;     end
      OP_ADD_B_SSAT: begin decoded.width = LANE_BYTE;  decoded.sat = SAT_SIGNED;   end
      OP_ADD_W_SSAT: begin decoded.width = LANE_WORD;  decoded.sat = SAT_SIGNED;   end
      OP_ADD_B_USAT: begin decoded.width = LANE_BYTE;  decoded.sat = SAT_UNSIGNED; end
      default:       decoded.illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Ctrl <= '0;
      outValid   <= 1'b0;
      illegalOp  <= 1'b0;
    end else begin
      stage1Ctrl <= decoded;
      outValid   <= stage1Ctrl.vld;
      illegalOp  <= stage1Ctrl.vld & stage1Ctrl.illegal;
    end
  end
endmodule

// File: rtl/simd_add_datapath.sv
module simd_add_datapath
  import simd_add_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  addCtrl_t          stage1Ctrl,
  output logic [DATA_W-1:0] result
);
  localparam int NUM_BYTES = DATA_W / 8;

  logic [DATA_W-1:0]    aReg, bReg;
  logic [DATA_W-1:0]    rawSum;
  logic [NUM_BYTES-1:0] byteCarry;
  logic [DATA_W-1:0]    satSum;
  int                   laneBytes;

  always_comb begin
    case (stage1Ctrl.width)
      LANE_WORD:  laneBytes = 2;
      LANE_DWORD: laneBytes = 4;
      default:    laneBytes = 1;
    endcase
  end

  // Stage 1: capture operands
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
    end else if (inValid) begin
      aReg <= opA;
      bReg <= opB;
    end
  end

  // Byte-granular carry chain, broken at each lane start
  always_comb begin
    logic       carry;
    logic [8:0] partial;
    carry = 1'b0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if ((i & (laneBytes - 1)) == 0) carry = 1'b0;
      partial = {1'b0, aReg[i*8 +: 8]} + {1'b0, bReg[i*8 +: 8]} + {8'd0, carry};
      rawSum[i*8 +: 8] = partial[7:0];
      byteCarry[i]     = partial[8];
      carry            = partial[8];
    end
  end

  // Per-lane clamp, decided at the lane's top byte
  always_comb begin
    int   top;
    logic aSign, bSign, rSign, sOvf;
    satSum = rawSum;
    for (int i = 0; i < NUM_BYTES; i++) begin
      top   = i | (laneBytes - 1);
      aSign = aReg[top*8 + 7];
      bSign = bReg[top*8 + 7];
      rSign = rawSum[top*8 + 7];
      sOvf  = (aSign == bSign) && (rSign != aSign);
      if (stage1Ctrl.sat == SAT_SIGNED && sOvf) begin
        if (i == top) satSum[i*8 +: 8] = aSign ? 8'h80 : 8'h7F;
        else          satSum[i*8 +: 8] = aSign ? 8'h00 : 8'hFF;
      end else if (stage1Ctrl.sat == SAT_UNSIGNED && byteCarry[top]) begin
        satSum[i*8 +: 8] = 8'hFF;
      end
    end
  end

  // Stage 2: result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (stage1Ctrl.vld) begin
      result <= stage1Ctrl.illegal ? '0 : satSum;
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_add_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegalOp
);
  addCtrl_t stage1Ctrl;

  simd_add_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .opSel      (opSel),
    .stage1Ctrl (stage1Ctrl),
    .outValid   (outValid),
    .illegalOp  (illegalOp)
  );

  simd_add_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .opA        (opA),
    .opB        (opB),
    .stage1Ctrl (stage1Ctrl),
    .result     (result)
  );
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [7:0]        opSel,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              illegalOp
);
  logic [1:0] sinceReset;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceReset <= 2'd0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  // R6
  latency_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2) |-> (outValid == $past(inValid, 2)));

  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (outValid && result == '0));

  // R1
  byte_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2 && outValid && $past(opSel, 2) == 8'hFC) |->
      (result[7:0] == 8'($past(opA[7:0], 2) + $past(opB[7:0], 2))));

  // R5
  usat_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2 && outValid && $past(opSel, 2) == 8'hDC) |->
      (result[7:0] >= $past(opA[7:0], 2)));
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/simd_sat_adder_test.sv
module simd_sat_adder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  opSel = '0;
  logic [63:0] opA = '0, opB = '0;
  logic        outValid, illegalOp;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  simd_sat_adder uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result), .illegalOp(illegalOp)
  );

  localparam int NV = 9;
  localparam logic [7:0]  V_OP [NV] = '{8'hFC, 8'hFE, 8'hEC, 8'hED, 8'hDC, 8'hFD, 8'hFC, 8'hEC, 8'h00};
  localparam logic [63:0] V_A  [NV] = '{64'h01FF7F80_00FF1020, 64'hFFFFFFFF_7FFFFFFF,
    64'h7F8050B0_01FF7F80, 64'h7FFF8000_1234FFFF, 64'hFF800100_F07F8064,
    64'h12345678_9ABCDEF0, 64'h80808080_80808080, 64'h01020304_05060708, 64'hFFFFFFFF_FFFFFFFF};
  localparam logic [63:0] V_B  [NV] = '{64'h01017F80_00011010, 64'h00000001_00000001,
    64'h01FF50B0_02FF807F, 64'h0001FFFF_1111FFFF, 64'h01800100_0F807F38,
    64'h11111111_11111111, 64'h80808080_80808080, 64'h10101010_10101010, 64'h00000000_00000001};
  localparam logic [63:0] V_E  [NV] = '{64'h0200FE00_00002030, 64'h00000000_80000000,
    64'h7F807F80_03FEFFFF, 64'h7FFF8000_2345FFFE, 64'hFFFF0200_FFFFFF9C,
    64'h0, 64'h0, 64'h11121314_15161718, 64'h0};
  localparam logic        V_I  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam string       V_R  [NV] = '{"R1/R7", "R2/R7", "R3", "R4/R7", "R5", "R8", "R1/R7", "R3", "R8"};

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    check64("R10 outValid", {63'd0, outValid}, 64'd0);
    check64("R10 illegalOp", {63'd0, illegalOp}, 64'd0);
    check64("R10 result", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Streamed vector table: R9 back-to-back, ordering
    for (int c = 0; c < NV + 2; c++) begin
      if (c >= 2) begin
        check64({"R9 outValid ", V_R[c-2]}, {63'd0, outValid}, 64'd1);
        check64({V_R[c-2], " result"}, result, V_E[c-2]);
        check64({V_R[c-2], " illegalOp"}, {63'd0, illegalOp}, {63'd0, V_I[c-2]});
      end
      if (c < NV) begin
        inValid = 1'b1; opSel = V_OP[c]; opA = V_A[c]; opB = V_B[c];
      end else begin
        inValid = 1'b0; opSel = 8'h00; opA = '0; opB = '0;
      end
      @(negedge clk);
    end
    check64("R6 idle after stream", {63'd0, outValid}, 64'd0);
    check64("R8 no flag without valid", {63'd0, illegalOp}, 64'd0);

    // R6: single issue latency
    inValid = 1'b1; opSel = 8'hED; opA = 64'h00010002_00030004; opB = 64'h00010001_00010001;
    @(negedge clk);
    inValid = 1'b0; opSel = 8'hFF;
    check64("R6 not after one edge", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    check64("R6 valid after two edges", {63'd0, outValid}, 64'd1);
    check64("R4 small sums", result, 64'h00020003_00040005);
    @(negedge clk);
    check64("R6 single pulse", {63'd0, outValid}, 64'd0);

    // R7: dword lane carry must not leak into the upper lane
    inValid = 1'b1; opSel = 8'hFE; opA = 64'h00000005_FFFFFFFF; opB = 64'h00000003_00000002;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check64("R7 dword boundary", result, 64'h00000008_00000001);

    // R5: unsigned byte clamps independently per lane
    inValid = 1'b1; opSel = 8'hDC; opA = 64'h00FF0000_000000FE; opB = 64'h00010000_00000001;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check64("R5 per-lane clamp", result, 64'h00FF0000_000000FF);

    // R10: reset mid-flight clears outputs
    inValid = 1'b1; opSel = 8'h00;
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    #1;
    check64("R10 async reset valid", {63'd0, outValid}, 64'd0);
    check64("R10 async reset flag", {63'd0, illegalOp}, 64'd0);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule